// File: doc/BRIEF.md
# Prioritised Two-Level Interrupt Controller

The block gathers 64 level-sensitive interrupt sources and presents them to a processor as two request lines: a normal request `irq_o`, gated by a per-source 4-bit priority and a programmable threshold, and a fast request `fiq_o`, which ignores priority altogether. Each source carries three bits of state: pending, enabled, and class (normal or fast). It also has a 4-bit priority nibble.

Software reaches the state through a word-addressed register bus with single-cycle read and write strobes. Enables can be written as whole 32-bit halves or set and cleared one source at a time by number. The pending vector can be overwritten from software.

Reading one of the two vector registers returns the winning source of that class. The same read acknowledges the winner by dropping its pending bit. A separate arbitration sub-block picks the normal winner, and another picks the fast winner.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, pending, enable, class, control and all priority nibbles are zero, the threshold register (word 1) reads 0x1F, and both request outputs are low.
- R2: Each pending bit takes the level of its source input at every clock edge, unless a force write or vector acknowledge acts on it in that cycle. Pending reads at word 18 (sources 63..32) and word 19 (sources 31..0) and cannot be written there.
- R3: `fiq_o` is the OR over all sources of pending AND enabled AND class, registered one cycle after the state it reflects.
- R4: `irq_o` is high one cycle after the state holds some source with pending AND enabled AND NOT class whose priority is strictly greater than the 5-bit threshold. With the threshold at 0x1F, any such source raises it.
- R5: A write to word 2 sets the enable bit numbered by data bits [5:0]; a write to word 3 clears it. Both words read as zero.
- R6: Words 4/5 hold enables for sources 63..32 / 31..0. Words 6/7 hold the class bits the same way, with 1 meaning fast.
- R7: Priority words 8..15 each hold eight 4-bit nibbles. Word 15 covers sources 0..7 and word 8 covers sources 56..63. Source n sits in bits [4*(n mod 8)+3 : 4*(n mod 8)].
- R8: A write to word 20 / 21 replaces pending bits 63..32 / 31..0 with the data for that cycle. Both words read as zero.
- R9: Word 16 returns (source << 16) | priority for the normal request of highest priority, with the highest source number winning ties, or 0xFFFFFFFF when none exists. A read clears the winner's pending bit at that edge.
- R10: Word 17 returns the lowest-numbered fast request, or 0xFFFFFFFF when none exists. A read clears that pending bit at that edge.
- R11: Words 22/23 read pending AND enabled AND NOT class (high/low half). Words 24/25 read pending AND enabled AND class.
- R12: Control (word 0) keeps only data bits 24, 22, 21, 20, 19 and 18, and other bits read zero. The threshold keeps only bits [4:0].
- R13: Word 0x40 reads the constant 4. Writes to words 0x40..0xBF, to read-only words and to unmapped words change no state, and unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Source levels |
| bus_addr_i | input | 10 | Word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe, needed for acknowledge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from current state |
| irq_o | output | 1 | Normal request, registered |
| fiq_o | output | 1 | Fast request, registered |

## Verification
The bench targets priority ties, where a design that favoured the lower source number would return the wrong vector and acknowledge the wrong source. It also targets thresholds at and around 15, where a non-strict compare would raise `irq_o` on an equal priority, and 0x1F, where a missing special case would hold the request low. It reverses the priority word order and shifts nibbles, which would put priorities on the wrong sources, and it checks enable-by-number with data above bit 5, where a design that failed to truncate would set nothing or the wrong bit. Acknowledge and force writes racing live source levels, and writes into the ignored vector window, expose a design that lets the register action persist, lets the level win, or stores into a dead address.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  parameter int NSRC    = 64;
  parameter int PRIO_W  = 4;
  parameter int THR_W   = 5;
  parameter int DATA_W  = 32;
  parameter int ADDR_W  = 10;
  localparam int PER_WORD = DATA_W / PRIO_W;
  localparam int PWORDS   = NSRC / PER_WORD;
  localparam int ID_W     = $clog2(NSRC);

  localparam int W_CTL    = 0;
  localparam int W_THR    = 1;
  localparam int W_ENNUM  = 2;
  localparam int W_DISNUM = 3;
  localparam int W_EN_HI  = 4;
  localparam int W_EN_LO  = 5;
  localparam int W_TY_HI  = 6;
  localparam int W_TY_LO  = 7;
  localparam int W_PRIO0  = 8;
  localparam int W_PRIO7  = 15;
  localparam int W_NVEC   = 16;
  localparam int W_FVEC   = 17;
  localparam int W_PND_HI = 18;
  localparam int W_PND_LO = 19;
  localparam int W_FRC_HI = 20;
  localparam int W_FRC_LO = 21;
  localparam int W_NP_HI  = 22;
  localparam int W_NP_LO  = 23;
  localparam int W_FP_HI  = 24;
  localparam int W_FP_LO  = 25;
  localparam int W_CONST  = 64;

  localparam logic [DATA_W-1:0] CTL_KEEP  = 32'h017C_0000;
  localparam logic [DATA_W-1:0] CONST_VAL = 32'd4;
  localparam logic [DATA_W-1:0] NO_VEC    = '1;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N  = 64,
  parameter int PW = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            any_o,
  output logic [IW-1:0]   id_o,
  output logic [PW-1:0]   prio_o
);
  // ascending scan with >= leaves the highest number on ties
  always_comb begin
    any_o  = 1'b0;
    id_o   = '0;
    prio_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!any_o || prio_i[i*PW +: PW] >= prio_o)) begin
        any_o  = 1'b1;
        id_o   = IW'(i);
        prio_o = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] id_o
);
  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        id_o  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int HALF = NSRC / 2;

  logic [NSRC-1:0]   pend_q, en_q, cls_q, pend_d;
  logic [DATA_W-1:0] prio_q [PWORDS];
  logic [THR_W-1:0]  thr_q;
  logic [DATA_W-1:0] ctl_q;
  logic              irq_q, fiq_q;

  logic [NSRC-1:0]        norm_req, fast_req;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic                   n_any, f_any;
  logic [ID_W-1:0]        n_id, f_id;
  logic [PRIO_W-1:0]      n_prio;
  int                     wa;
  logic                   wr_ev, rd_ev;

  assign wa    = int'(bus_addr_i);
  assign wr_ev = bus_wr_i;
  assign rd_ev = bus_rd_i;

  assign norm_req = pend_q & en_q & ~cls_q;
  assign fast_req = pend_q & en_q & cls_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_prio
    assign prio_flat[s*PRIO_W +: PRIO_W] =
      prio_q[s / PER_WORD][PRIO_W*(s % PER_WORD) +: PRIO_W];
  end

  irq_prio_arb #(.N(NSRC), .PW(PRIO_W)) i_norm_arb (
    .req_i  (norm_req),
    .prio_i (prio_flat),
    .any_o  (n_any),
    .id_o   (n_id),
    .prio_o (n_prio)
  );

  irq_low_pick #(.N(NSRC)) i_fast_pick (
    .req_i (fast_req),
    .any_o (f_any),
    .id_o  (f_id)
  );

  logic [DATA_W-1:0] nvec, fvec;
  assign nvec = n_any ? ((DATA_W'(n_id) << 16) | DATA_W'(n_prio)) : NO_VEC;
  assign fvec = f_any ? DATA_W'(f_id) : NO_VEC;

  always_comb begin
    bus_rdata_o = '0;
    case (wa)
      W_CTL:    bus_rdata_o = ctl_q;
      W_THR:    bus_rdata_o = DATA_W'(thr_q);
      W_EN_HI:  bus_rdata_o = en_q[NSRC-1:HALF];
      W_EN_LO:  bus_rdata_o = en_q[HALF-1:0];
      W_TY_HI:  bus_rdata_o = cls_q[NSRC-1:HALF];
      W_TY_LO:  bus_rdata_o = cls_q[HALF-1:0];
      W_NVEC:   bus_rdata_o = nvec;
      W_FVEC:   bus_rdata_o = fvec;
      W_PND_HI: bus_rdata_o = pend_q[NSRC-1:HALF];
      W_PND_LO: bus_rdata_o = pend_q[HALF-1:0];
      W_NP_HI:  bus_rdata_o = norm_req[NSRC-1:HALF];
      W_NP_LO:  bus_rdata_o = norm_req[HALF-1:0];
      W_FP_HI:  bus_rdata_o = fast_req[NSRC-1:HALF];
      W_FP_LO:  bus_rdata_o = fast_req[HALF-1:0];
      W_CONST:  bus_rdata_o = CONST_VAL;
      default: begin
        // priority word 8 holds the top sources, word 15 the bottom ones
        if (wa >= W_PRIO0 && wa <= W_PRIO7) bus_rdata_o = prio_q[W_PRIO7 - wa];
      end
    endcase
  end

  // pending follows the level; register actions override for one cycle
  always_comb begin
    pend_d = src_i;
    if (wr_ev && wa == W_FRC_HI) pend_d[NSRC-1:HALF] = bus_wdata_i;
    if (wr_ev && wa == W_FRC_LO) pend_d[HALF-1:0]    = bus_wdata_i;
    if (rd_ev && wa == W_NVEC && n_any) pend_d[n_id] = 1'b0;
    if (rd_ev && wa == W_FVEC && f_any) pend_d[f_id] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
      cls_q  <= '0;
      thr_q  <= '1;
      ctl_q  <= '0;
      for (int k = 0; k < PWORDS; k++) prio_q[k] <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_ev) begin
        case (wa)
          W_CTL:    ctl_q <= bus_wdata_i & CTL_KEEP;
          W_THR:    thr_q <= bus_wdata_i[THR_W-1:0];
          W_ENNUM:  en_q[bus_wdata_i[ID_W-1:0]] <= 1'b1;
          W_DISNUM: en_q[bus_wdata_i[ID_W-1:0]] <= 1'b0;
          W_EN_HI:  en_q[NSRC-1:HALF]  <= bus_wdata_i;
          W_EN_LO:  en_q[HALF-1:0]     <= bus_wdata_i;
          W_TY_HI:  cls_q[NSRC-1:HALF] <= bus_wdata_i;
          W_TY_LO:  cls_q[HALF-1:0]    <= bus_wdata_i;
          default: begin
            if (wa >= W_PRIO0 && wa <= W_PRIO7) prio_q[W_PRIO7 - wa] <= bus_wdata_i;
          end
        endcase
      end
    end
  end

  logic irq_d;
  assign irq_d = n_any && (thr_q == '1 || {1'b0, n_prio} > thr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= |fast_req;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  a_r3_fiq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == $past(|(pend_q & en_q & cls_q)));

  a_r4_irq_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|norm_req));

  a_r5_set_by_num: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && wa == W_ENNUM) |=> en_q[$past(bus_wdata_i[ID_W-1:0])]);

  a_r5_clr_by_num: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && wa == W_DISNUM) |=> !en_q[$past(bus_wdata_i[ID_W-1:0])]);

  a_r2_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_i && !(bus_wr_i && (wa == W_FRC_HI || wa == W_FRC_LO)))
      |=> pend_q == $past(src_i));

  a_r8_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && wa == W_FRC_LO) |=> pend_q[HALF-1:0] == $past(bus_wdata_i));

  a_r9_winner_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_any |-> norm_req[n_id]);

  a_r10_lowest_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_any |-> (fast_req[f_id] && (fast_req & ((NSRC'(1) << f_id) - NSRC'(1))) == '0));

  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && wa == W_NVEC && n_any) |=> !pend_q[$past(n_id)]);
endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic [9:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, fiq_o;

  irq_vec_ctrl i_irq_vec_ctrl (.*);

  always #10 clk_i = ~clk_i;

  int n_vec = 0, n_bad = 0;

  // reference state
  bit [63:0] m_pend, m_en, m_cls;
  bit [31:0] m_prio [8];
  bit [4:0]  m_thr = 5'h1F;
  bit [31:0] m_ctl;
  bit        m_irq, m_fiq;

  function automatic int sp(int n);
    return int'((m_prio[n / 8] >> (4 * (n % 8))) & 32'hF);
  endfunction

  function automatic int nwin(output int pr);
    int id = -1;
    pr = -1;
    for (int i = 63; i >= 0; i--)
      if (m_pend[i] && m_en[i] && !m_cls[i] && sp(i) > pr) begin
        pr = sp(i); id = i;
      end
    return id;
  endfunction

  function automatic int fwin();
    for (int i = 0; i < 64; i++)
      if (m_pend[i] && m_en[i] && m_cls[i]) return i;
    return -1;
  endfunction

  function automatic bit [31:0] mread(int a);
    int id, pr;
    bit [63:0] np = m_pend & m_en & ~m_cls;
    bit [63:0] fp = m_pend & m_en & m_cls;
    case (a)
      0: return m_ctl;
      1: return 32'(m_thr);
      4: return m_en[63:32];
      5: return m_en[31:0];
      6: return m_cls[63:32];
      7: return m_cls[31:0];
      16: begin id = nwin(pr); return id < 0 ? 32'hFFFF_FFFF : 32'((id << 16) | pr); end
      17: begin id = fwin(); return id < 0 ? 32'hFFFF_FFFF : 32'(id); end
      18: return m_pend[63:32];
      19: return m_pend[31:0];
      22: return np[63:32];
      23: return np[31:0];
      24: return fp[63:32];
      25: return fp[31:0];
      64: return 32'd4;
      default: if (a >= 8 && a <= 15) return m_prio[15 - a];
    endcase
    return 32'd0;
  endfunction

  function automatic string rtag(int a);
    if (a == 0 || a == 1) return "R12";
    if (a == 2 || a == 3) return "R5";
    if (a >= 4 && a <= 7) return "R6";
    if (a >= 8 && a <= 15) return "R7";
    if (a == 16) return "R9";
    if (a == 17) return "R10";
    if (a == 18 || a == 19) return "R2";
    if (a == 20 || a == 21) return "R8";
    if (a >= 22 && a <= 25) return "R11";
    return "R13";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_now(int a);
    check(rtag(a), bus_rdata_o, mread(a));
    check("R4 irq_o", 32'(irq_o), 32'(m_irq));
    check("R3 fiq_o", 32'(fiq_o), 32'(m_fiq));
  endtask

  // one bus cycle: drive at negedge, compare before the edge, advance model
  task automatic step(int a, bit wr, bit rd, bit [31:0] wd, bit [63:0] src);
    int id, pr;
    bit [63:0] nxt;
    @(negedge clk_i);
    bus_addr_i = 10'(a); bus_wr_i = wr; bus_rd_i = rd; bus_wdata_i = wd; src_i = src;
    #2;
    compare_now(a);
    id = nwin(pr);
    m_irq = (id >= 0) && (m_thr == 5'h1F || pr > int'(m_thr));
    m_fiq = |(m_pend & m_en & m_cls);
    nxt = src;
    if (wr && a == 20) nxt[63:32] = wd;
    if (wr && a == 21) nxt[31:0] = wd;
    if (rd && a == 16 && id >= 0) nxt[id] = 1'b0;
    if (rd && a == 17 && fwin() >= 0) nxt[fwin()] = 1'b0;
    if (wr) begin
      case (a)
        0: m_ctl = wd & 32'h017C_0000;
        1: m_thr = wd[4:0];
        2: m_en[wd[5:0]] = 1'b1;
        3: m_en[wd[5:0]] = 1'b0;
        4: m_en[63:32] = wd;
        5: m_en[31:0] = wd;
        6: m_cls[63:32] = wd;
        7: m_cls[31:0] = wd;
        default: if (a >= 8 && a <= 15) m_prio[15 - a] = wd;
      endcase
    end
    m_pend = nxt;
  endtask

  task automatic sweep(bit [63:0] src);
    int al [30] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,18,19,20,21,
                    22,23,24,25,26,64,100,191,300,1023};
    foreach (al[k]) step(al[k], 1'b0, 1'b0, 32'd0, src);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    bit [63:0] s;
    int al [24] = '{0,1,2,3,4,5,6,7,8,9,12,15,16,17,16,17,20,21,64,128,191,18,23,25};
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset values
    check("R1 irq_o", 32'(irq_o), 32'd0);
    check("R1 fiq_o", 32'(fiq_o), 32'd0);
    sweep('0);

    // R5: by-number with upper data bits set
    step(2, 1, 0, 32'hFFFF_FFC5, '0);   // source 5
    step(2, 1, 0, 32'h0000_007F, '0);   // source 63
    step(5, 0, 0, 0, '0);
    step(4, 0, 0, 0, '0);
    step(3, 1, 0, 32'h0000_0045, '0);   // clears 5
    step(5, 0, 0, 0, '0);

    // R7/R9: equal priorities, highest number wins
    step(4, 1, 0, 32'hFFFF_FFFF, '0);
    step(5, 1, 0, 32'hFFFF_FFFF, '0);
    step(15, 1, 0, 32'h0000_7007, '0);  // src0=7, src3=7
    step(8, 1, 0, 32'h3000_0000, '0);   // src63=3
    s = 64'h8000_0000_0000_0009;
    step(16, 0, 0, 0, s);
    step(16, 0, 0, 0, s);
    step(16, 0, 1, 0, s);               // ack src3
    step(19, 0, 0, 0, s);

    // R4: threshold boundaries
    foreach (al[k]) if (k < 0) ;
    step(1, 1, 0, 32'd7, s);
    step(1, 0, 0, 0, s); step(1, 0, 0, 0, s);
    step(1, 1, 0, 32'd6, s);
    step(1, 0, 0, 0, s); step(1, 0, 0, 0, s);
    step(1, 1, 0, 32'd15, s);
    step(1, 0, 0, 0, s); step(1, 0, 0, 0, s);
    step(1, 1, 0, 32'hFFFF_FFFF, s);
    step(1, 0, 0, 0, s); step(1, 0, 0, 0, s);

    // R10/R3: fast class
    step(7, 1, 0, 32'h0000_0009, s);
    step(17, 0, 0, 0, s); step(17, 0, 1, 0, s); step(17, 0, 0, 0, s);
    step(24, 0, 0, 0, s); step(25, 0, 0, 0, s);

    // R8: force against live levels
    step(21, 1, 0, 32'h1234_5678, s);
    step(19, 0, 0, 0, s); step(19, 0, 0, 0, s);
    step(20, 1, 0, 32'hA5A5_0001, '0);
    step(18, 0, 0, 0, '0);

    // R12/R13: control masking, dead window writes
    step(0, 1, 0, 32'hFFFF_FFFF, '0);
    step(0, 0, 0, 0, '0);
    step(64, 1, 0, 32'hFFFF_FFFF, '0);
    step(191, 1, 0, 32'hFFFF_FFFF, '0);
    step(18, 1, 0, 32'hFFFF_FFFF, '0);
    step(22, 1, 0, 32'hFFFF_FFFF, '0);
    sweep('0);

    // mixed traffic
    s = '0;
    for (int c = 0; c < 3000; c++) begin
      int a = al[$urandom_range(23, 0)];
      bit wr = ($urandom_range(2, 0) == 0);
      bit rd = !wr && ($urandom_range(1, 0) == 0);
      bit [31:0] wd = $urandom();
      if (a == 1) wd = (c % 5 == 0) ? 32'h1F : 32'($urandom_range(16, 0));
      if ($urandom_range(3, 0) == 0) s ^= 64'd1 << $urandom_range(63, 0);
      if ($urandom_range(49, 0) == 0) s = {$urandom(), $urandom()};
      step(a, wr, rd, wd, s);
    end
    sweep(s);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule